// File: doc/BRIEF.md
# Loadable Ring / Twisted-Ring Shift Counter

This block is a small shift-register counter with a parameterised number of stages. The default is four. A mode input picks one of two actions on each rising clock edge. The first action is a parallel load, which copies a user pattern into every stage at once. The second is a right shift, in which each stage takes the value held by its left neighbour.

A feedback-select input chooses what enters the leftmost stage during a shift. With the straight feedback, the rightmost stage's value enters unchanged, so a loaded pattern simply circulates. With the twisted feedback, the complement of the rightmost stage enters, so a run of ones followed by a run of zeros walks through the register. With four stages that sequence has eight states.

The stage values appear on a single output vector. The most significant bit is the leftmost (first) stage, and bit 0 is the rightmost (last) stage. A synchronous reset clears the register.

Top module: `ringtwist_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge, all stages become 0 after that edge. Reset takes priority over a load or a shift requested in the same cycle.
- R2: When `load_mode` is 1 (and `rst` is 0), `stage_q` takes `load_val` on one rising edge. `load_val[N-1]` goes to the leftmost stage and `load_val[0]` goes to the rightmost stage.
- R3: When `load_mode` is 0, each stage except the leftmost takes its left neighbour's value on the edge, that is `stage_q[i]` takes the old `stage_q[i+1]`.
- R4: With `twist_sel` = 0 (straight), the leftmost stage takes the old rightmost value. A loaded 1000 then runs through 0100, 0010 and 0001 before returning to 1000.
- R5: With `twist_sel` = 1 (twisted), the leftmost stage takes the complement of the old rightmost value. Starting at 0000, the states are 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then 0000 again.
- R6: In straight mode, any loaded pattern is back at its starting value after exactly N shifts.
- R7: In twisted mode, a legal start state (ones followed by zeros, or the reverse) is the bitwise complement of itself after N shifts. It is back to its start after exactly 2N shifts.
- R8: `twist_sel` is sampled on the same edge as the shift. Changing it between shifts alters only the feedback bit of the next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_mode | input | 1 | 1 = parallel load, 0 = right shift |
| twist_sel | input | 1 | 0 = straight feedback, 1 = inverted feedback |
| load_val | input | N | Pattern for parallel load, MSB = leftmost stage |
| stage_q | output | N | Stage values, MSB = leftmost stage |

## Verification
The bench builds the counter with its default of four stages. At that width, the straight cycle of 4 and the twisted cycle of 8 both complete within a few clocks, so every state of both sequences can be listed in a vector table by hand. At the same width, the half-cycle complement property and the full return to start can be checked for several loaded patterns. Mid-run feedback switching and reset racing a load are also covered.

// File: rtl/ringtwist_pkg.sv
package ringtwist_pkg;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } ring_mode_e;

  typedef enum logic {
    FB_STRAIGHT = 1'b0,
    FB_TWISTED  = 1'b1
  } fb_kind_e;

  // Bit fed back into the leftmost stage from the rightmost stage's value.
  function automatic logic tail_feedback(input logic tail_bit, input fb_kind_e kind);
    return (kind == FB_TWISTED) ? ~tail_bit : tail_bit;
  endfunction

  // Value one stage takes on the next edge.
  function automatic logic stage_next(input logic rst, input ring_mode_e mode,
                                      input logic load_bit, input logic shift_bit,
                                      input logic cur_bit);
    logic nxt;
    nxt = cur_bit;
    if (rst)                    nxt = 1'b0;
    else if (mode == MODE_LOAD) nxt = load_bit;
    else                        nxt = shift_bit;
    return nxt;
  endfunction

endpackage

// File: rtl/ring_feedback.sv
module ring_feedback
  import ringtwist_pkg::*;
(
  input  logic tail_bit,
  input  logic twist_sel,
  output logic head_bit
);

  always_comb begin
    head_bit = tail_feedback(tail_bit, fb_kind_e'(twist_sel));
  end

endmodule

// File: rtl/ring_stage.sv
module ring_stage
  import ringtwist_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_mode,
  input  logic load_bit,
  input  logic shift_bit,
  output logic q
);

  logic q_next;

  always_comb begin
    q_next = stage_next(rst, ring_mode_e'(load_mode), load_bit, shift_bit, q);
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end

endmodule

// File: rtl/ringtwist_counter.sv
module ringtwist_counter
  import ringtwist_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_mode,
  input  logic         twist_sel,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] stage_q
);

  localparam int unsigned HEAD = N - 1;
  localparam int unsigned TAIL = 0;

  // Named internal events for the assertions.
  logic         fb_bit;
  logic [N-1:0] shift_src;
  logic         shift_evt;
  logic         load_evt;

  assign shift_evt = !rst && (load_mode == MODE_SHIFT);
  assign load_evt  = !rst && (load_mode == MODE_LOAD);

  ring_feedback fb_i (
    .tail_bit (stage_q[TAIL]),
    .twist_sel(twist_sel),
    .head_bit (fb_bit)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == HEAD) begin : g_head
        assign shift_src[i] = fb_bit;
      end else begin : g_body
        assign shift_src[i] = stage_q[i+1];
      end
      ring_stage st_i (
        .clk      (clk),
        .rst      (rst),
        .load_mode(load_mode),
        .load_bit (load_val[i]),
        .shift_bit(shift_src[i]),
        .q        (stage_q[i])
      );
    end
  endgenerate

  // R1: reset wins over everything
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (stage_q == '0));

  // R2: parallel load lands in one edge
  a_r2_parallel_load: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (stage_q == $past(load_val)));

  // R3: right shift moves every non-head stage by one place
  a_r3_right_shift: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> (stage_q[N-2:0] == $past(stage_q[N-1:1])));

  // R4: straight feedback copies the tail
  a_r4_straight_fb: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !twist_sel) |=> (stage_q[HEAD] == $past(stage_q[TAIL])));

  // R5: twisted feedback inverts the tail
  a_r5_twisted_fb: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && twist_sel) |=> (stage_q[HEAD] != $past(stage_q[TAIL])));

  // R6: a straight shift preserves the number of ones
  a_r6_ones_kept: assert property (@(posedge clk) disable iff (rst)
    (shift_evt && !twist_sel) |=> ($countones(stage_q) == $countones($past(stage_q))));

endmodule

// File: tb/ringtwist_counter_tb_top.sv
module ringtwist_counter_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_mode = 1'b0;
  logic         twist_sel = 1'b0;
  logic [N-1:0] load_val = '0;
  logic [N-1:0] stage_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ringtwist_counter #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .load_mode(load_mode), .twist_sel(twist_sel),
    .load_val(load_val), .stage_q(stage_q)
  );

  // {rst, load_mode, twist_sel, load_val[3:0], expected[3:0]}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {3'b110, 4'b1111, 4'b0000},  // R1 reset beats load
    {3'b010, 4'b1000, 4'b1000},  // R2 load 1000
    {3'b000, 4'b0000, 4'b0100},  // R4
    {3'b000, 4'b0000, 4'b0010},
    {3'b000, 4'b0000, 4'b0001},
    {3'b000, 4'b0000, 4'b1000},  // R4 wraps
    {3'b010, 4'b0000, 4'b0000},  // R2 load 0000
    {3'b001, 4'b0000, 4'b1000},  // R5
    {3'b001, 4'b0000, 4'b1100},
    {3'b001, 4'b0000, 4'b1110},
    {3'b001, 4'b0000, 4'b1111},
    {3'b001, 4'b0000, 4'b0111},
    {3'b001, 4'b0000, 4'b0011},
    {3'b001, 4'b0000, 4'b0001},
    {3'b001, 4'b0000, 4'b0000},  // R5 wraps
    {3'b010, 4'b1011, 4'b1011},  // R2
    {3'b000, 4'b0000, 4'b1101},  // R3 straight
    {3'b001, 4'b0000, 4'b0110},  // R8 switch to twisted
    {3'b000, 4'b0000, 4'b0011}   // R8 switch back
  };

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (stage_q !== exp) begin
      errors++;
      $display("FAIL %s: stage_q=%b expected=%b", req, stage_q, exp);
    end
  endtask

  // Apply inputs away from the edge, clock once, sample 1 ns after the edge.
  task automatic step(input logic r, input logic ld, input logic tw, input logic [N-1:0] v);
    rst = r; load_mode = ld; twist_sel = tw; load_val = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [N-1:0] pat;
    #1;
    step(1'b1, 1'b0, 1'b0, '0);
    check("R1 reset state", '0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:4]);
      check($sformatf("R1/R2/R3/R4/R5/R8 vector %0d", k), VEC[k][3:0]);
    end

    // R6: straight period equals N for several patterns
    for (int p = 0; p < 4; p++) begin
      pat = (p == 0) ? 4'b1010 : (p == 1) ? 4'b0110 : (p == 2) ? 4'b1101 : 4'b0001;
      step(1'b0, 1'b1, 1'b0, pat);
      for (int s = 0; s < N; s++) step(1'b0, 1'b0, 1'b0, '0);
      check("R6 straight period", pat);
    end

    // R7: twisted half period gives complement, full period returns
    for (int p = 0; p < 3; p++) begin
      pat = (p == 0) ? 4'b0000 : (p == 1) ? 4'b1100 : 4'b0111;
      step(1'b0, 1'b1, 1'b0, pat);
      for (int s = 0; s < N; s++) step(1'b0, 1'b0, 1'b1, '0);
      check("R7 twisted half period complement", ~pat);
      for (int s = 0; s < N; s++) step(1'b0, 1'b0, 1'b1, '0);
      check("R7 twisted full period", pat);
    end

    // R1: reset in the middle of a twisted run
    step(1'b0, 1'b1, 1'b0, 4'b1110);
    step(1'b0, 1'b0, 1'b1, '0);
    check("R5 mid-run shift", 4'b1111);
    step(1'b1, 1'b0, 1'b1, '0);
    check("R1 reset during shift", 4'b0000);

    // R8: feedback changes on alternating shifts from 0001
    step(1'b0, 1'b1, 1'b0, 4'b0001);
    step(1'b0, 1'b0, 1'b0, '0);
    check("R8 straight then", 4'b1000);
    step(1'b0, 1'b0, 1'b1, '0);
    check("R8 twisted next", 4'b1100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule